// File: doc/BRIEF.md
# Register Operand Bypass Unit

This block sits in the register-read stage of a five-stage in-order pipeline (fetch, register read, execute, memory, writeback). It supplies the two source operands, A and B, of the instruction being decoded. A producer further down the pipe may not have written its result to the register file yet. For each operand the block therefore compares the source register number with the destination register of the instructions now in the execute, memory and writeback stages. When a stage matches, its in-flight result replaces the stale register file value.

The writeback value is selected in two parts, which keeps the number of bypass sources at three. The execute stage chooses between the arithmetic result and the return address (PC+4) of a link-writing branch or jump. The memory stage carries that choice forward unchanged. The writeback stage then chooses between the carried value and load data. The writeback bypass taps the output of that second choice.

Instructions that write no register, such as stores, present register 31 as their destination and clear their write flag. Register 31 always reads as zero and is never the target of a bypass. The block is purely combinational, with one matching path per operand.

Top module: `byp_operand_unit`

## Requirements
- R1: When no downstream stage qualifies for an operand and its source register is not 31, the operand equals the register file read data for that operand.
- R2: A stage qualifies for an operand when its write flag is 1, its destination equals the source register number, and the source is not 31. When the execute stage qualifies, the operand is `ex_pc4` if `ex_link` is 1 and `ex_alu` if `ex_link` is 0.
- R3: When the memory stage qualifies and the execute stage does not, the operand equals `mm_val`.
- R4: When only the writeback stage qualifies, the operand is `wb_mem` if `wb_load` is 1 and `wb_alu` if `wb_load` is 0.
- R5: When several stages qualify, the youngest producer wins. The execute stage takes precedence over the memory stage, and the memory stage over the writeback stage.
- R6: A source register number of 31 (all ones) yields an operand of zero. This holds whatever the register file data is, and also when any stage names register 31 as a written destination.
- R7: A stage whose write flag is 0 has no effect on either operand, even when its destination equals the source register number.
- R8: Operands A and B are selected independently, so each can take a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number for operand A |
| src_b | input | 5 | Source register number for operand B |
| rf_a | input | 32 | Register file read data for operand A |
| rf_b | input | 32 | Register file read data for operand B |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_alu | input | 32 | Execute-stage arithmetic result |
| ex_pc4 | input | 32 | Execute-stage return address (PC+4) |
| ex_link | input | 1 | Execute-stage instruction writes its return address |
| mm_dst | input | 5 | Destination register of the memory-stage instruction |
| mm_wr | input | 1 | Memory-stage instruction writes a register |
| mm_val | input | 32 | Memory-stage value, as chosen in the execute stage |
| wb_dst | input | 5 | Destination register of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_alu | input | 32 | Writeback-stage carried value, as chosen in the execute stage |
| wb_mem | input | 32 | Writeback-stage load data |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench sets up cases where two or three stages name the same register with different values. A priority inverted toward older stages would hand the operand a stale result from the memory or writeback stage. It drives register 31 as a written destination in every stage while the register file returns non-zero data; a design missing the zero guard would bypass garbage into an operand that must read zero. It also toggles the link and load selects and the write flags with matching destinations. A swapped split select would deliver the arithmetic result in place of a return address or load data, and an ignored write flag would let a store overwrite a live operand. A randomized sweep over a small register range then checks both operands against a reference model, to expose any crosstalk between A and B.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int REG_W_DEF  = 5;
  localparam int DATA_W_DEF = 32;
  localparam int NUM_OPND   = 2;
  localparam int NUM_STAGES = 3;

  // stage index order doubles as priority order (lower index = younger)
  localparam int ST_EX = 0;
  localparam int ST_MM = 1;
  localparam int ST_WB = 2;

  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_EX = 2'd1,
    SRC_MM = 2'd2,
    SRC_WB = 2'd3
  } byp_src_e;

  // youngest qualifying stage wins
  function automatic byp_src_e pick_src(input logic [NUM_STAGES-1:0] hit);
    if (hit[ST_EX])      return SRC_EX;
    else if (hit[ST_MM]) return SRC_MM;
    else if (hit[ST_WB]) return SRC_WB;
    else                 return SRC_RF;
  endfunction
endpackage

// File: rtl/byp_stage_taps.sv
module byp_stage_taps #(
  parameter int DATA_W = byp_pkg::DATA_W_DEF
) (
  input  logic [DATA_W-1:0] ex_alu,
  input  logic [DATA_W-1:0] ex_pc4,
  input  logic              ex_link,
  input  logic [DATA_W-1:0] wb_alu,
  input  logic [DATA_W-1:0] wb_mem,
  input  logic              wb_load,
  output logic [DATA_W-1:0] ex_tap,
  output logic [DATA_W-1:0] wb_tap
);
  // first half of the split writeback select: arithmetic vs return address
  function automatic logic [DATA_W-1:0] early_sel(
    input logic [DATA_W-1:0] arith, input logic [DATA_W-1:0] ret, input logic link);
    return link ? ret : arith;
  endfunction

  // second half: carried value vs load data
  function automatic logic [DATA_W-1:0] late_sel(
    input logic [DATA_W-1:0] carried, input logic [DATA_W-1:0] mdata, input logic load);
    return load ? mdata : carried;
  endfunction

  always_comb begin
    ex_tap = early_sel(ex_alu, ex_pc4, ex_link);
    wb_tap = late_sel(wb_alu, wb_mem, wb_load);
  end
endmodule

// File: rtl/byp_match.sv
module byp_match
  import byp_pkg::*;
#(
  parameter int REG_W = REG_W_DEF
) (
  input  logic [REG_W-1:0]            src,
  input  logic [NUM_STAGES-1:0][REG_W-1:0] dst,
  input  logic [NUM_STAGES-1:0]       wr,
  output logic [NUM_STAGES-1:0]       hit,
  output byp_src_e                    sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  function automatic logic qualifies(
    input logic [REG_W-1:0] s, input logic [REG_W-1:0] d, input logic w);
    return w && (s == d) && (s != ZERO_REG);
  endfunction

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cmp
    assign hit[g] = qualifies(src, dst[g], wr[g]);
  end

  assign sel = pick_src(hit);
endmodule

// File: rtl/byp_opmux.sv
module byp_opmux
  import byp_pkg::*;
#(
  parameter int REG_W  = REG_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic [REG_W-1:0]  src,
  input  byp_src_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [DATA_W-1:0] mm_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  always_comb begin
    if (src == ZERO_REG) begin
      opnd = '0;
    end else begin
      unique case (sel)
        SRC_EX:  opnd = ex_val;
        SRC_MM:  opnd = mm_val;
        SRC_WB:  opnd = wb_val;
        default: opnd = rf_val;
      endcase
    end
  end
endmodule

// File: rtl/byp_operand_unit.sv
module byp_operand_unit
  import byp_pkg::*;
#(
  parameter int REG_W  = REG_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              ex_wr,
  input  logic [DATA_W-1:0] ex_alu,
  input  logic [DATA_W-1:0] ex_pc4,
  input  logic              ex_link,
  input  logic [REG_W-1:0]  mm_dst,
  input  logic              mm_wr,
  input  logic [DATA_W-1:0] mm_val,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wr,
  input  logic [DATA_W-1:0] wb_alu,
  input  logic [DATA_W-1:0] wb_mem,
  input  logic              wb_load,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  logic [DATA_W-1:0] ex_tap, wb_tap;
  logic [NUM_STAGES-1:0][REG_W-1:0] dst_vec;
  logic [NUM_STAGES-1:0]            wr_vec;
  logic [NUM_OPND-1:0][REG_W-1:0]   src_vec;
  logic [NUM_OPND-1:0][DATA_W-1:0]  rf_vec;
  logic [NUM_OPND-1:0][DATA_W-1:0]  out_vec;
  logic [NUM_OPND-1:0][NUM_STAGES-1:0] hit_w;
  byp_src_e                            sel_w [NUM_OPND];

  assign dst_vec[ST_EX] = ex_dst;
  assign dst_vec[ST_MM] = mm_dst;
  assign dst_vec[ST_WB] = wb_dst;
  assign wr_vec[ST_EX]  = ex_wr;
  assign wr_vec[ST_MM]  = mm_wr;
  assign wr_vec[ST_WB]  = wb_wr;
  assign src_vec[0] = src_a;
  assign src_vec[1] = src_b;
  assign rf_vec[0]  = rf_a;
  assign rf_vec[1]  = rf_b;
  assign opnd_a = out_vec[0];
  assign opnd_b = out_vec[1];

  byp_stage_taps #(.DATA_W(DATA_W)) taps_i (
    .ex_alu(ex_alu), .ex_pc4(ex_pc4), .ex_link(ex_link),
    .wb_alu(wb_alu), .wb_mem(wb_mem), .wb_load(wb_load),
    .ex_tap(ex_tap), .wb_tap(wb_tap)
  );

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    byp_match #(.REG_W(REG_W)) match_i (
      .src(src_vec[i]), .dst(dst_vec), .wr(wr_vec),
      .hit(hit_w[i]), .sel(sel_w[i])
    );

    byp_opmux #(.REG_W(REG_W), .DATA_W(DATA_W)) mux_i (
      .src(src_vec[i]), .sel(sel_w[i]), .rf_val(rf_vec[i]),
      .ex_val(ex_tap), .mm_val(mm_val), .wb_val(wb_tap),
      .opnd(out_vec[i])
    );

    // checks on each operand path, relating match results to the mux output
    always_comb begin
      a_r1_rf_default: assert (!(sel_w[i] == SRC_RF && src_vec[i] != ZERO_REG)
                               || out_vec[i] == rf_vec[i])
        else $error("R1: operand %0d not register file data", i);
      a_r2_link_ret: assert (!(sel_w[i] == SRC_EX && ex_link && src_vec[i] != ZERO_REG)
                             || out_vec[i] == ex_pc4)
        else $error("R2: operand %0d missed return address", i);
      a_r4_load_data: assert (!(sel_w[i] == SRC_WB && wb_load && src_vec[i] != ZERO_REG)
                              || out_vec[i] == wb_mem)
        else $error("R4: operand %0d missed load data", i);
      a_r5_youngest: assert (!hit_w[i][ST_EX] || sel_w[i] == SRC_EX)
        else $error("R5: operand %0d execute stage lost priority", i);
      a_r5_mem_over_wb: assert (hit_w[i][ST_EX] || !hit_w[i][ST_MM] || sel_w[i] == SRC_MM)
        else $error("R5: operand %0d memory stage lost priority", i);
      a_r6_zero_reg: assert (src_vec[i] != ZERO_REG || (out_vec[i] == '0 && hit_w[i] == '0))
        else $error("R6: operand %0d register 31 not zero", i);
      a_r7_wr_gate: assert ((hit_w[i] & ~wr_vec) == '0)
        else $error("R7: operand %0d hit on non-writing stage", i);
    end
  end
endmodule

// File: tb/byp_operand_unit_tb.sv
module byp_operand_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [4:0]  src_a, src_b, ex_dst, mm_dst, wb_dst;
  logic [31:0] rf_a, rf_b, ex_alu, ex_pc4, mm_val, wb_alu, wb_mem;
  logic        ex_wr, ex_link, mm_wr, wb_wr, wb_load;
  logic [31:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  byp_operand_unit dut_i (
    .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_alu(ex_alu), .ex_pc4(ex_pc4), .ex_link(ex_link),
    .mm_dst(mm_dst), .mm_wr(mm_wr), .mm_val(mm_val),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_alu(wb_alu), .wb_mem(wb_mem), .wb_load(wb_load),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // reference model written from the requirements
  function automatic logic [31:0] model(input logic [4:0] s, input logic [31:0] rf);
    if (s == 5'd31) return 32'h0;
    if (ex_wr && ex_dst == s) return ex_link ? ex_pc4 : ex_alu;
    if (mm_wr && mm_dst == s) return mm_val;
    if (wb_wr && wb_dst == s) return wb_load ? wb_mem : wb_alu;
    return rf;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    src_a = 5'd1; src_b = 5'd2; rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002;
    ex_dst = 5'd1; ex_wr = 1'b0; ex_alu = 32'h1111_1111; ex_pc4 = 32'h0000_1004; ex_link = 1'b0;
    mm_dst = 5'd1; mm_wr = 1'b0; mm_val = 32'h2222_2222;
    wb_dst = 5'd1; wb_wr = 1'b0; wb_alu = 32'h3333_3333; wb_mem = 32'h4444_4444; wb_load = 1'b0;
  endtask

  task automatic t_idle_state();
    idle(); settle();
    check("R1 idle A", opnd_a, 32'hA0A0_0001);
    check("R1 idle B", opnd_b, 32'hB0B0_0002);
  endtask

  task automatic t_no_match();
    idle(); ex_wr = 1; ex_dst = 5'd7; mm_wr = 1; mm_dst = 5'd8; wb_wr = 1; wb_dst = 5'd9;
    settle();
    check("R1 no match A", opnd_a, rf_a);
    check("R1 no match B", opnd_b, rf_b);
  endtask

  task automatic t_ex_stage();
    idle(); ex_wr = 1; ex_dst = 5'd1; settle();
    check("R2 ex arith", opnd_a, 32'h1111_1111);
    ex_link = 1; settle();
    check("R2 ex link", opnd_a, 32'h0000_1004);
  endtask

  task automatic t_mm_stage();
    idle(); mm_wr = 1; mm_dst = 5'd2; settle();
    check("R3 mem B", opnd_b, 32'h2222_2222);
    check("R3 mem A untouched", opnd_a, rf_a);
  endtask

  task automatic t_wb_stage();
    idle(); wb_wr = 1; wb_dst = 5'd1; settle();
    check("R4 wb carried", opnd_a, 32'h3333_3333);
    wb_load = 1; settle();
    check("R4 wb load", opnd_a, 32'h4444_4444);
  endtask

  task automatic t_priority();
    idle(); ex_wr = 1; mm_wr = 1; wb_wr = 1; settle();
    check("R5 ex over all", opnd_a, 32'h1111_1111);
    ex_wr = 0; settle();
    check("R5 mem over wb", opnd_a, 32'h2222_2222);
    mm_dst = 5'd5; ex_wr = 1; ex_dst = 5'd6; wb_load = 1; settle();
    check("R5 wb when younger miss", opnd_a, 32'h4444_4444);
  endtask

  task automatic t_zero_reg();
    idle(); src_a = 5'd31; src_b = 5'd31; rf_a = 32'hDEAD_BEEF; rf_b = 32'hFFFF_FFFF;
    ex_dst = 5'd31; ex_wr = 1; mm_dst = 5'd31; mm_wr = 1; wb_dst = 5'd31; wb_wr = 1;
    settle();
    check("R6 zero A", opnd_a, 32'h0);
    check("R6 zero B", opnd_b, 32'h0);
  endtask

  task automatic t_wr_off();
    idle(); src_b = 5'd1; rf_b = 32'hCAFE_0001; settle();
    check("R7 wr off A", opnd_a, 32'hA0A0_0001);
    check("R7 wr off B", opnd_b, 32'hCAFE_0001);
    ex_link = 1; wb_load = 1; settle();
    check("R7 selects ignored", opnd_a, 32'hA0A0_0001);
  endtask

  task automatic t_indep();
    idle(); ex_wr = 1; ex_dst = 5'd1; wb_wr = 1; wb_dst = 5'd2; settle();
    check("R8 A from ex", opnd_a, 32'h1111_1111);
    check("R8 B from wb", opnd_b, 32'h3333_3333);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 4); src_a = (r == 4) ? 5'd31 : 5'(r);
      r = $urandom_range(0, 4); src_b = (r == 4) ? 5'd31 : 5'(r);
      r = $urandom_range(0, 4); ex_dst = (r == 4) ? 5'd31 : 5'(r);
      r = $urandom_range(0, 4); mm_dst = (r == 4) ? 5'd31 : 5'(r);
      r = $urandom_range(0, 4); wb_dst = (r == 4) ? 5'd31 : 5'(r);
      ex_wr = 1'($urandom); mm_wr = 1'($urandom); wb_wr = 1'($urandom);
      ex_link = 1'($urandom); wb_load = 1'($urandom);
      rf_a = $urandom; rf_b = $urandom; ex_alu = $urandom; ex_pc4 = $urandom;
      mm_val = $urandom; wb_alu = $urandom; wb_mem = $urandom;
      settle();
      check("R5/R8 sweep A", opnd_a, model(src_a, rf_a));
      check("R5/R8 sweep B", opnd_b, model(src_b, rf_b));
    end
  endtask

  initial begin
    idle();
    t_idle_state();
    t_no_match();
    t_ex_stage();
    t_mm_stage();
    t_wb_stage();
    t_priority();
    t_zero_reg();
    t_wr_off();
    t_indep();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule